// File: doc/BRIEF.md
# Four-Channel Prescaled Interval Timer

This block holds four identical countdown channels behind a 32-bit register bus with per-byte write enables. Software programs a prescale factor, a terminal count and a reload mode for each channel, then sets the channel's run bit. The channel counts system clocks and, once the programmed interval has elapsed, emits a single-cycle interrupt request on the line assigned to that channel.

The interval length is the product of the prescale value plus one and the terminal count plus one. When it expires, a channel in reload mode starts a fresh interval from the values held in its registers at that moment. A channel in single-shot mode drops its own run bit and idles. Clearing the run bit from software halts a channel at once, and no request follows. The interrupt controller, the bus fabric and clock generation lie outside this block.

Top module: `qit_top`

## Requirements
- R1: After reset every control word reads 0x0000FF00, every count word reads 0x00000000, and no interrupt line is high.
- R2: Channel c occupies byte addresses 8c (control) and 8c+4 (count). In the control word, bit 0 is the run bit, bit 1 selects reload mode and bits 15:8 hold the prescale value PD. The count word holds the terminal value TCV in bits 15:0. All other bits read as zero.
- R3: Byte enable k writes only bits 8k+7..8k of the addressed word, and the other bits keep their value.
- R4: A write that takes the run bit from 0 to 1 loads and starts the channel. If that write lands on clock edge E, the request is high in the cycle after edge E+(PD+1)(TCV+1).
- R5: Each expiry raises exactly one single-cycle pulse. Channels 0, 1, 2 and 3 use lines 0, 1, 9 and 10 of a 16-line request vector, and no other line is ever driven high.
- R6: In reload mode an expiry restarts the channel with the PD and TCV held at that moment, so the next request follows after (PD+1)(TCV+1) more edges.
- R7: In single-shot mode the expiry clears the run bit. A read of the control word then shows bit 0 as zero, with the other fields intact.
- R8: A write that takes the run bit from 1 to 0 halts the channel at once, and no request follows from the interval that was interrupted.
- R9: A write that leaves the run bit unchanged updates the stored fields without restarting the count. New PD or TCV values take effect only at the next start or reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every count step is one cycle |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe for the addressed word |
| busAddr | input | 5 | Byte address of the word to access |
| busWdata | input | 32 | Write data |
| busByteEn | input | 4 | Per-byte write enables |
| busRdata | output | 32 | Live read data for busAddr |
| irqLines | output | 16 | Interrupt request pulses |

## Verification
The bench predicts the exact cycle of every request from the period product and compares it against each pulse. A design that multiplied wrongly, or counted PD or TCV without the plus one, would miss by a whole number of cycles. Rewriting a running channel's control word with the run bit still set catches a design that restarts on level instead of edge: its pulse would arrive late. Changing the count while a channel runs in reload mode catches a design that applies the new count too early (a shortened first interval) or never (a wrong second interval). A stop issued one cycle before an expiry catches a design that lets the pending pulse out. A single-shot channel read back after expiry catches a design that fails to clear its own run bit.

// File: rtl/qit_pkg.sv
package qit_pkg;
  localparam int PD_W = 8;
  localparam int PD_LSB = 8;

  typedef struct packed {
    logic start;
    logic stop;
    logic [PD_W-1:0] startPd;
  } chanCmd_t;

  function automatic int irqLineOf(input int ch);
    return (ch < 2) ? ch : ch + 7;
  endfunction
endpackage

// File: rtl/qit_ctrl.sv
module qit_ctrl
  import qit_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W = 16,
  parameter int ADDR_W = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0] busWdata,
  input  logic [3:0] busByteEn,
  input  logic [NUM_CH-1:0] expire,
  output logic [31:0] busRdata,
  output chanCmd_t [NUM_CH-1:0] cmd,
  output logic [NUM_CH-1:0] enVec,
  output logic [NUM_CH-1:0] arVec,
  output logic [NUM_CH-1:0][PD_W-1:0] pdArr,
  output logic [NUM_CH-1:0][CNT_W-1:0] tcvArr
);
  localparam int CH_W = ADDR_W - 3;

  logic [31:0] laneMask;
  always_comb begin
    for (int b = 0; b < 4; b++) laneMask[8*b +: 8] = {8{busByteEn[b]}};
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic hitChan, selCtrl, selCnt;
    logic newEn, newAr;
    logic [PD_W-1:0] newPd;
    logic [31:0] tcvWide, tcvMerged;

    assign hitChan = busWrEn && (busAddr[ADDR_W-1:3] == CH_W'(c));
    assign selCtrl = hitChan && !busAddr[2];
    assign selCnt  = hitChan && busAddr[2];

    assign newEn = busByteEn[0] ? busWdata[0] : enVec[c];
    assign newAr = busByteEn[0] ? busWdata[1] : arVec[c];
    assign newPd = busByteEn[1] ? busWdata[PD_LSB +: PD_W] : pdArr[c];

    assign cmd[c].start   = selCtrl && newEn && !enVec[c];
    assign cmd[c].stop    = selCtrl && !newEn && enVec[c];
    assign cmd[c].startPd = newPd;

    assign tcvWide   = 32'(tcvArr[c]);
    assign tcvMerged = (tcvWide & ~laneMask) | (busWdata & laneMask);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        enVec[c]  <= 1'b0;
        arVec[c]  <= 1'b0;
        pdArr[c]  <= '1;
        tcvArr[c] <= '0;
      end else begin
        if (selCtrl) begin
          arVec[c] <= newAr;
          pdArr[c] <= newPd;
        end
        if (expire[c] && !arVec[c]) enVec[c] <= 1'b0;
        else if (selCtrl)           enVec[c] <= newEn;
        if (selCnt) tcvArr[c] <= tcvMerged[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    busRdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (busAddr[ADDR_W-1:3] == CH_W'(c)) begin
        if (busAddr[2]) busRdata = 32'(tcvArr[c]);
        else busRdata = 32'({pdArr[c], 6'b0, arVec[c], enVec[c]});
      end
    end
  end
endmodule

// File: rtl/qit_datapath.sv
module qit_datapath
  import qit_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W = 16
) (
  input  logic clk,
  input  logic rstN,
  input  chanCmd_t [NUM_CH-1:0] cmd,
  input  logic [NUM_CH-1:0] enVec,
  input  logic [NUM_CH-1:0] arVec,
  input  logic [NUM_CH-1:0][PD_W-1:0] pdArr,
  input  logic [NUM_CH-1:0][CNT_W-1:0] tcvArr,
  output logic [NUM_CH-1:0] expire,
  output logic [NUM_CH-1:0] irqVec
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic [PD_W-1:0] preCnt, pdHold;
    logic [CNT_W-1:0] mainCnt;
    logic preZero, atZero;

    assign preZero   = (preCnt == '0);
    assign atZero    = preZero && (mainCnt == '0);
    assign expire[c] = enVec[c] && atZero && !cmd[c].stop;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        preCnt    <= '0;
        pdHold    <= '0;
        mainCnt   <= '0;
        irqVec[c] <= 1'b0;
      end else begin
        irqVec[c] <= expire[c];
        if (cmd[c].start) begin
          preCnt  <= cmd[c].startPd;
          pdHold  <= cmd[c].startPd;
          mainCnt <= tcvArr[c];
        end else if (expire[c]) begin
          if (arVec[c]) begin
            preCnt  <= pdArr[c];
            pdHold  <= pdArr[c];
            mainCnt <= tcvArr[c];
          end
        end else if (enVec[c] && !cmd[c].stop) begin
          if (preZero) begin
            preCnt  <= pdHold;
            mainCnt <= mainCnt - 1'b1;
          end else begin
            preCnt <= preCnt - 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/qit_top.sv
module qit_top
  import qit_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W = 16,
  parameter int IRQ_LINES = 16,
  localparam int ADDR_W = $clog2(NUM_CH) + 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0] busWdata,
  input  logic [3:0] busByteEn,
  output logic [31:0] busRdata,
  output logic [IRQ_LINES-1:0] irqLines
);
  chanCmd_t [NUM_CH-1:0] cmd;
  logic [NUM_CH-1:0] enVec, arVec, expire, irqVec;
  logic [NUM_CH-1:0][PD_W-1:0] pdArr;
  logic [NUM_CH-1:0][CNT_W-1:0] tcvArr;

  qit_ctrl #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWdata(busWdata), .busByteEn(busByteEn), .expire(expire),
    .busRdata(busRdata), .cmd(cmd), .enVec(enVec), .arVec(arVec),
    .pdArr(pdArr), .tcvArr(tcvArr)
  );

  qit_datapath #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .enVec(enVec), .arVec(arVec),
    .pdArr(pdArr), .tcvArr(tcvArr), .expire(expire), .irqVec(irqVec)
  );

  always_comb begin
    irqLines = '0;
    for (int c = 0; c < NUM_CH; c++) irqLines[irqLineOf(c)] = irqVec[c];
  end
endmodule

// File: rtl/qit_checker.sv
module qit_checker
  import qit_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int IRQ_LINES = 16
) (
  input logic clk,
  input logic rstN,
  input logic busWrEn,
  input chanCmd_t [NUM_CH-1:0] cmd,
  input logic [NUM_CH-1:0] enVec,
  input logic [NUM_CH-1:0] arVec,
  input logic [NUM_CH-1:0] expire,
  input logic [NUM_CH-1:0] irqVec,
  input logic [IRQ_LINES-1:0] irqLines
);
  logic [IRQ_LINES-1:0] usedMask;
  always_comb begin
    usedMask = '0;
    for (int c = 0; c < NUM_CH; c++) usedMask[irqLineOf(c)] = 1'b1;
  end

  // R5
  unused_line_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqLines & ~usedMask) == '0);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R8
    stop_silences_chk: assert property (@(posedge clk) disable iff (!rstN)
      cmd[c].stop |=> !irqVec[c]);
    // R7
    oneshot_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      (expire[c] && !arVec[c]) |=> !enVec[c]);
    // R4
    irq_needs_run_chk: assert property (@(posedge clk) disable iff (!rstN)
      irqVec[c] |-> $past(enVec[c]));
    // R4
    start_by_write_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(enVec[c]) |-> $past(busWrEn));
    // R6
    reload_keeps_run_chk: assert property (@(posedge clk) disable iff (!rstN)
      (expire[c] && arVec[c] && !cmd[c].stop) |=> enVec[c]);
  end
endmodule

bind qit_top qit_checker #(.NUM_CH(NUM_CH), .IRQ_LINES(IRQ_LINES)) u_chk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .cmd(cmd), .enVec(enVec),
  .arVec(arVec), .expire(expire), .irqVec(irqVec), .irqLines(irqLines)
);

// File: tb/qit_top_bench.sv
module qit_top_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0;
  logic [4:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [3:0] busByteEn = '0;
  logic [31:0] busRdata;
  logic [15:0] irqLines;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  int lastEdge = 0;
  bit done = 1'b0;
  int expQ[4][$];
  int lineOf[4] = '{0, 1, 9, 10};

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  qit_top u_qit_top (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWdata(busWdata), .busByteEn(busByteEn), .busRdata(busRdata),
    .irqLines(irqLines)
  );

  // caller is at a negedge; write lands on the next posedge
  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be);
    busWrEn = 1'b1; busAddr = a; busWdata = d; busByteEn = be;
    lastEdge = cyc + 1;
    @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b0; busByteEn = '0;
  endtask

  task automatic chk_rd(input logic [4:0] a, input logic [31:0] exp, input string req);
    busAddr = a;
    #1;
    vectors++;
    if (busRdata !== exp) begin
      fails++;
      $display("FAIL %s addr %0h: got %08h expected %08h", req, a, busRdata, exp);
    end
  endtask

  task automatic expect_irq(input int ch, input int at);
    expQ[ch].push_back(at);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: compares every pulse against the predicted cycle
  always @(negedge clk) begin
    if (rstN && !done) begin
      for (int ch = 0; ch < 4; ch++) begin
        if (expQ[ch].size() > 0 && expQ[ch][0] < cyc) begin
          vectors++; fails++;
          $display("FAIL R4 ch%0d: no pulse, got none expected cycle %0d", ch, expQ[ch][0]);
          void'(expQ[ch].pop_front());
        end
        if (irqLines[lineOf[ch]]) begin
          vectors++;
          if (expQ[ch].size() == 0) begin
            fails++;
            $display("FAIL R8 ch%0d: pulse at cycle %0d expected none", ch, cyc);
          end else if (expQ[ch][0] != cyc) begin
            fails++;
            $display("FAIL R4 ch%0d: pulse at cycle %0d expected %0d", ch, cyc, expQ[ch][0]);
            void'(expQ[ch].pop_front());
          end else begin
            void'(expQ[ch].pop_front());
          end
        end
      end
      if ((irqLines & ~16'h0603) != 0) begin
        vectors++; fails++;
        $display("FAIL R5 stray lines: got %04h expected 0000", irqLines & ~16'h0603);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int e;
    idle(3);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int ch = 0; ch < 4; ch++) begin
      chk_rd(5'(8*ch), 32'h0000FF00, "R1");
      chk_rd(5'(8*ch + 4), 32'h0, "R1");
    end
    vectors++;
    if (irqLines !== '0) begin
      fails++; $display("FAIL R1 irq: got %04h expected 0000", irqLines);
    end

    // R2/R3: byte-lane writes, unused bits read zero
    wr(5'h1C, 32'hFFFF_ABCD, 4'b0001);
    chk_rd(5'h1C, 32'h0000_00CD, "R3");
    wr(5'h1C, 32'hFFFF_12FF, 4'b0010);
    chk_rd(5'h1C, 32'h0000_12CD, "R2");
    wr(5'h18, 32'hFFFF_01FC, 4'b0010);
    chk_rd(5'h18, 32'h0000_0100, "R3");
    wr(5'h1C, 32'h0000_0002, 4'b0011);

    // R3/R4: start ch3 via lane 0 only, PD=1 TCV=2 -> 6 cycles, line 10
    wr(5'h18, 32'h0000_FF01, 4'b0001);
    expect_irq(3, lastEdge + 6);
    idle(10);
    // R7 single shot cleared run bit
    chk_rd(5'h18, 32'h0000_0100, "R7");

    // R4/R7: ch0 PD=2 TCV=3 -> 12 cycles
    wr(5'h04, 32'd3, 4'b1111);
    wr(5'h00, 32'h0000_0201, 4'b1111);
    expect_irq(0, lastEdge + 12);
    idle(16);
    chk_rd(5'h00, 32'h0000_0200, "R7");

    // R4: minimum period, ch2 PD=0 TCV=0 -> 1 cycle, line 9
    wr(5'h14, 32'd0, 4'b1111);
    wr(5'h10, 32'h0000_0001, 4'b1111);
    expect_irq(2, lastEdge + 1);
    idle(4);
    chk_rd(5'h10, 32'h0000_0000, "R7");

    // R6/R9: ch1 reload, TCV=4 then changed to 1 while running
    wr(5'h0C, 32'd4, 4'b1111);
    wr(5'h08, 32'h0000_0003, 4'b1111);
    e = lastEdge;
    expect_irq(1, e + 5);
    wr(5'h0C, 32'd1, 4'b1111);
    expect_irq(1, e + 7);
    expect_irq(1, e + 9);
    while (cyc < e + 9) @(negedge clk);
    // R8: stop one edge before the next expiry would resolve
    wr(5'h08, 32'h0000_0002, 4'b1111);
    idle(8);
    chk_rd(5'h08, 32'h0000_0002, "R8");

    // R9: rewriting a running control word keeps the count going
    wr(5'h04, 32'd3, 4'b1111);
    wr(5'h00, 32'h0000_0301, 4'b1111);
    e = lastEdge;
    expect_irq(0, e + 16);
    idle(4);
    wr(5'h00, 32'h0000_0001, 4'b1111);
    chk_rd(5'h00, 32'h0000_0001, "R9");
    idle(16);
    chk_rd(5'h00, 32'h0000_0000, "R7");

    // R8: stop well before expiry, no pulse at all
    wr(5'h14, 32'd20, 4'b1111);
    wr(5'h10, 32'h0000_0001, 4'b1111);
    idle(5);
    wr(5'h10, 32'h0000_0000, 4'b1111);
    idle(30);

    // R4: full prescale from reset PD=0xFF, TCV=1 -> 512 cycles
    wr(5'h0C, 32'd1, 4'b1111);
    wr(5'h08, 32'h0000_FF01, 4'b1111);
    expect_irq(1, lastEdge + 512);
    idle(520);

    for (int ch = 0; ch < 4; ch++) begin
      vectors++;
      if (expQ[ch].size() != 0) begin
        fails++;
        $display("FAIL R4 ch%0d pending: got %0d expected 0", ch, expQ[ch].size());
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule